// File: doc/BRIEF.md
# MII Management Polling Engine

This block drives the two-wire station management interface of an Ethernet PHY. It derives the management clock MDC from the system clock by a selectable division and shifts clause-22 read frames out on MDIO. While auto-poll is enabled it reads one PHY register over and over. Each result appears on a 16-bit read-data output together with a one-cycle valid strobe.

Two settings are chosen at run time. A two-bit rate selector picks the MDC frequency. Only the slowest setting, 2.5 MHz from a 50 MHz system clock, keeps to the standard management timing. The two faster settings, up to 5 MHz and 10 MHz, are for PHYs known to accept them. A three-bit dwell selector sets how many idle MDC periods pass between the end of one polled frame and the start of the next. This keeps the polling traffic on the management bus low.

MDC runs continuously. A frame always begins on a falling MDC edge. MDIO is driven only while the engine owns the line, and it is released for the turnaround and for the data bits the PHY returns.

Top module: `mdio_poll_engine`

## Requirements
- R1: While reset is held, and after it until auto-poll is enabled, `mdc` is low or free-running, `mdio_oe` is low, `rd_valid` is low, and no frame is sent.
- R2: One MDC period lasts DIV_SLOW (default 20) system clocks for rate code 0, DIV_MID (10) for code 1 and DIV_FAST (5) for code 2. The high phase lasts the period minus half the period, rounded down (20→10, 10→5, 5→3).
- R3: The 46 driven bits of a frame are, MSB first: 32 ones, then 0,1, then 1,0, then the 5-bit PHY address, then the 5-bit register address. `mdio_oe` is high for all 46 of them.
- R4: `mdio_out` and `mdio_oe` change only in the cycle in which `mdc` falls. They are therefore stable whenever `mdc` rises.
- R5: `mdio_oe` is low for bits 46..63, which are the two turnaround bits and the 16 data bits. `mdio_in` is sampled on the rising MDC edge of data bits 48..63, and the first of these becomes `rd_data[15]`. `rd_data` is updated and `rd_valid` is high in the cycle in which `mdc` rises for bit 63.
- R6: With auto-poll on, the time from one frame's start to the next is 64 + N MDC periods. N is 1 for dwell code 0 and 2^(DWELL_SHIFT+k-1) for code k = 1..5. With the default DWELL_SHIFT of 7 this gives 128, 256, 512, 1024 and 2048.
- R7: Dwell codes 6 and 7 give the same gap as code 5.
- R8: When auto-poll is cleared during a frame, that frame still completes with its `rd_valid`, and no further frame starts. When it is cleared during the dwell, the dwell is abandoned. Re-enabling then starts a frame at the next falling MDC edge, so its first rising edge comes within two MDC periods.
- R9: A frame starts only in a cycle in which `poll_en` is high.
- R10: `rd_valid` is never high for two cycles in a row, and there is exactly one pulse per completed frame.
- R11: Rate code 3 behaves exactly like rate code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | MDC rate code (0: slow, 1: mid, 2: fast, 3: slow) |
| dwell_sel | input | 3 | Idle-gap code applied between polled frames |
| poll_en | input | 1 | Auto-poll enable |
| phy_addr | input | 5 | PHY address placed in each frame |
| reg_addr | input | 5 | Register address placed in each frame |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | High while the engine drives MDIO |
| mdio_in | input | 1 | Serial data from the PHY |
| rd_data | output | 16 | Last register value read |
| rd_valid | output | 1 | One-cycle strobe marking a new `rd_data` |

## Verification
Some properties are checked on every cycle: output changes line up with falling MDC edges, the read strobe coincides with a rising edge and lasts one cycle, a frame starts only under an active enable, and the MDC high phase never exceeds its slowest length. Other behaviour shows up only in the bench scenarios. These include the exact MDC periods for each rate code, the bit pattern of each frame, the captured read value, the start-to-start spacing for every dwell code including the reserved ones, and the behaviour when auto-poll is dropped mid-frame or mid-dwell.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;
    localparam int TA_FIRST   = PRE_BITS + HDR_BITS;   // first released bit
    localparam int DATA_FIRST = TA_FIRST + 2;          // first sampled bit
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = DATA_FIRST + DATA_BITS;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [3:0] SOF_READ = 4'b0110;         // start 01, read opcode 10

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FRAME,
        SEQ_DWELL
    } seq_state_e;

    typedef struct packed {
        logic [3:0] sof_op;
        logic [4:0] phy;
        logic [4:0] regad;
    } mgmt_hdr_t;

    // Division ratio for a rate code; code 3 falls back to the slow one.
    function automatic int pick_div(input logic [1:0] code,
                                    input int d_slow, input int d_mid, input int d_fast);
        case (code)
            2'd1:    return d_mid;
            2'd2:    return d_fast;
            default: return d_slow;
        endcase
    endfunction

    // Idle MDC periods after a frame; reserved codes use the longest gap.
    function automatic int unsigned dwell_len(input logic [2:0] code, input int shift);
        if (code == 3'd0)
            return 1;
        else if (code <= 3'd5)
            return 32'd1 << (shift + int'(code) - 1);
        else
            return 32'd1 << (shift + 4);
    endfunction

    // Value driven for a given frame bit position.
    function automatic logic frame_bit(input logic [IDX_W-1:0] idx, input mgmt_hdr_t hdr);
        int i;
        logic [3:0] pos;
        i = int'(idx);
        if (i < PRE_BITS) return 1'b1;
        if (i < TA_FIRST) begin
            pos = 4'(TA_FIRST - 1 - i);
            return hdr[pos];
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_poll_pkg::*;
#(
    parameter int DIV_SLOW = 20,
    parameter int DIV_MID  = 10,
    parameter int DIV_FAST = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       mdc,
    output logic       rise_tick,
    output logic       fall_tick
);
    localparam int DMAX = (DIV_SLOW > DIV_MID) ?
                          ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                          ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
    localparam int CW = $clog2(DMAX + 1);

    logic [CW-1:0] cnt_q, div_q, high_len;

    // high phase takes the larger half of an odd ratio
    assign high_len  = div_q - (div_q >> 1);
    assign rise_tick = (cnt_q >= div_q - CW'(1));
    assign fall_tick = !rise_tick && (cnt_q == high_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            // start in the low phase, so the first event is a rising edge
            cnt_q <= CW'(DIV_SLOW - DIV_SLOW / 2);
            div_q <= CW'(DIV_SLOW);
            mdc   <= 1'b0;
        end else if (rise_tick) begin
            cnt_q <= '0;
            div_q <= CW'(pick_div(rate_sel, DIV_SLOW, DIV_MID, DIV_FAST));  // R2 R11
            mdc   <= 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            if (fall_tick) mdc <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_dwell_timer.sv
module mdio_dwell_timer
    import mdio_poll_pkg::*;
#(
    parameter int DWELL_SHIFT = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       abort,
    input  logic [2:0] code,
    input  logic       step,
    output logic       expire
);
    localparam int DW = DWELL_SHIFT + 5;

    logic [DW-1:0] left_q;
    logic          run_q;

    assign expire = run_q && step && (left_q == DW'(1));

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            run_q  <= 1'b0;
            left_q <= '0;
        end else if (load) begin
            run_q  <= 1'b1;
            left_q <= DW'(dwell_len(code, DWELL_SHIFT));  // R6 R7
        end else if (run_q && step) begin
            left_q <= left_q - DW'(1);
            if (left_q == DW'(1)) run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_poll_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 poll_en,
    input  logic [4:0]           phy_addr,
    input  logic [4:0]           reg_addr,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_in,
    input  logic                 dwell_expire,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_valid,
    output logic                 dwell_load,
    output logic                 dwell_abort
);
    seq_state_e           st_q;
    logic [IDX_W-1:0]     idx_q;
    mgmt_hdr_t            hdr_q;
    logic [DATA_BITS-2:0] sh_q;
    logic                 last_bit;

    assign last_bit    = (idx_q == IDX_W'(FRAME_BITS - 1));
    assign dwell_load  = (st_q == SEQ_FRAME) && rise_tick && last_bit && poll_en;
    assign dwell_abort = (st_q == SEQ_DWELL) && !poll_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SEQ_IDLE;
            idx_q    <= '0;
            hdr_q    <= '0;
            sh_q     <= '0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    // R9: only an enabled engine starts, on a falling edge (R4)
                    if (fall_tick && poll_en) begin
                        st_q     <= SEQ_FRAME;
                        idx_q    <= '0;
                        hdr_q    <= '{sof_op: SOF_READ, phy: phy_addr, regad: reg_addr};
                        mdio_out <= 1'b1;
                        mdio_oe  <= 1'b1;
                    end
                end
                SEQ_FRAME: begin
                    if (fall_tick) begin
                        mdio_out <= frame_bit(idx_q, hdr_q);            // R3
                        mdio_oe  <= (idx_q < IDX_W'(TA_FIRST));         // R5 release
                    end
                    if (rise_tick) begin
                        if (idx_q >= IDX_W'(DATA_FIRST))
                            sh_q <= {sh_q[DATA_BITS-3:0], mdio_in};
                        if (last_bit) begin
                            rd_data  <= {sh_q, mdio_in};
                            rd_valid <= 1'b1;
                            idx_q    <= '0;
                            st_q     <= poll_en ? SEQ_DWELL : SEQ_IDLE; // R8
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                SEQ_DWELL: begin
                    if (!poll_en || dwell_expire) st_q <= SEQ_IDLE;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_poll_engine.sv
module mdio_poll_engine
    import mdio_poll_pkg::*;
#(
    parameter int DIV_SLOW    = 20,
    parameter int DIV_MID     = 10,
    parameter int DIV_FAST    = 5,
    parameter int DWELL_SHIFT = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  rate_sel,
    input  logic [2:0]  dwell_sel,
    input  logic        poll_en,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in,
    output logic [15:0] rd_data,
    output logic        rd_valid
);
    logic rise_tick, fall_tick;
    logic dwell_load, dwell_abort, dwell_expire;

    mdio_mdc_gen #(
        .DIV_SLOW (DIV_SLOW),
        .DIV_MID  (DIV_MID),
        .DIV_FAST (DIV_FAST)
    ) u_clk (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_dwell_timer #(
        .DWELL_SHIFT (DWELL_SHIFT)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load   (dwell_load),
        .abort  (dwell_abort),
        .code   (dwell_sel),
        .step   (rise_tick),
        .expire (dwell_expire)
    );

    mdio_frame_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .poll_en      (poll_en),
        .phy_addr     (phy_addr),
        .reg_addr     (reg_addr),
        .rise_tick    (rise_tick),
        .fall_tick    (fall_tick),
        .mdio_in      (mdio_in),
        .dwell_expire (dwell_expire),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .dwell_load   (dwell_load),
        .dwell_abort  (dwell_abort)
    );

endmodule

// File: rtl/mdio_poll_engine_chk.sv
module mdio_poll_engine_chk #(
    parameter int MAX_HI = 10
) (
    input logic clk,
    input logic rst,
    input logic poll_en,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe,
    input logic rd_valid
);
    localparam int RW = $clog2(MAX_HI + 2);

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst)
            hi_run <= '0;
        else if (!mdc)
            hi_run <= '0;
        else if (hi_run != '1)
            hi_run <= hi_run + RW'(1);
    end

    // R2: no high phase is longer than the slowest setting allows
    assert_high_phase_R2: assert property (@(posedge clk) disable iff (rst)
        mdc |-> (hi_run < RW'(MAX_HI)));

    // R4: line changes only together with a falling MDC edge
    assert_drive_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_oe) || !$stable(mdio_out)) |-> $fell(mdc));

    // R5: result appears with a rising MDC edge
    assert_valid_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(mdc));

    // R9: driving begins only under an active enable
    assert_start_enabled_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> $past(poll_en));

    // R10: strobe lasts a single cycle
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

bind mdio_poll_engine mdio_poll_engine_chk #(
    .MAX_HI (DIV_SLOW - DIV_SLOW / 2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .poll_en  (poll_en),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_valid (rd_valid)
);

// File: tb/sim_mdio_poll_engine.sv
`timescale 1ns/1ps
module sim_mdio_poll_engine;

    localparam int SHIFT = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  rate_sel;
    logic [2:0]  dwell_sel;
    logic        poll_en;
    logic [4:0]  phy_addr;
    logic [4:0]  reg_addr;
    logic        mdc, mdio_out, mdio_oe, mdio_in, rd_valid;
    logic [15:0] rd_data;

    int nchk = 0;
    int nerr = 0;
    int starts = 0;
    int frames = 0;
    int npulse = 0;
    bit in_frame = 0;
    bit done = 0;
    time start_t [0:255];

    always #5 clk = ~clk;

    mdio_poll_engine #(.DWELL_SHIFT(SHIFT)) u0 (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .dwell_sel(dwell_sel),
        .poll_en(poll_en), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic int exp_div(input logic [1:0] r);
        return (r == 2'd1) ? 10 : (r == 2'd2) ? 5 : 20;
    endfunction

    function automatic int exp_gap(input int d);
        if (d == 0) return 1;
        if (d <= 5) return 1 << (SHIFT + d - 1);
        return 1 << (SHIFT + 4);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // PHY model and frame monitor
    initial begin : phy_model
        int   rk;
        time  last_rise;
        logic [45:0] seen, exp_hdr;
        logic [15:0] resp;
        logic drv_out, drv_oe;
        bit   oe_bad, per_bad, hi_bad, r4_bad;
        longint per_act, hi_act;
        rk = 0; last_rise = 0; seen = '0; exp_hdr = '0; resp = '0;
        drv_out = 1'b1; drv_oe = 1'b0;
        oe_bad = 0; per_bad = 0; hi_bad = 0; r4_bad = 0; per_act = 0; hi_act = 0;
        mdio_in = 1'b1;
        forever begin
            @(posedge mdc or negedge mdc);
            #1;
            if (mdc) begin
                if (!in_frame && mdio_oe) begin
                    in_frame = 1; rk = 0; seen = '0;
                    oe_bad = 0; per_bad = 0; hi_bad = 0; r4_bad = 0;
                    start_t[starts] = $time;
                    starts++;
                    resp = {phy_addr, reg_addr, 6'(starts)};
                    exp_hdr = {32'hFFFF_FFFF, 4'b0110, phy_addr, reg_addr};
                end else if (in_frame) begin
                    if (($time - last_rise) != time'(exp_div(rate_sel) * 10)) begin
                        per_bad = 1; per_act = longint'(($time - last_rise) / 10);
                    end
                    if (mdio_out !== drv_out || mdio_oe !== drv_oe) r4_bad = 1;
                end
                last_rise = $time;
                if (in_frame) begin
                    if (rk < 46) begin
                        seen = {seen[44:0], mdio_out};
                        if (!mdio_oe) oe_bad = 1;
                    end else if (mdio_oe) begin
                        oe_bad = 1;
                    end
                    rk++;
                    if (rk == 64) begin
                        in_frame = 0;
                        frames++;
                        chk(seen == exp_hdr, "R3 header", longint'(seen), longint'(exp_hdr));
                        chk(!oe_bad, "R5 oe pattern", longint'(oe_bad), 0);
                        chk(rd_valid == 1'b1, "R5 valid", longint'(rd_valid), 1);
                        chk(rd_data == resp, "R5 data", longint'(rd_data), longint'(resp));
                        chk(!per_bad, "R2 period", per_act, exp_div(rate_sel));
                        chk(!hi_bad, "R2 high", hi_act,
                            exp_div(rate_sel) - exp_div(rate_sel) / 2);
                        chk(!r4_bad, "R4 stable at rise", longint'(r4_bad), 0);
                    end
                end
            end else begin
                if (in_frame) begin
                    if (($time - last_rise) !=
                        time'((exp_div(rate_sel) - exp_div(rate_sel) / 2) * 10)) begin
                        hi_bad = 1; hi_act = longint'(($time - last_rise) / 10);
                    end
                end
                drv_out = mdio_out;
                drv_oe  = mdio_oe;
                mdio_in = (in_frame && rk >= 48 && rk < 64) ? resp[63 - rk] : 1'b1;
            end
        end
    end

    initial begin : pulse_count
        forever begin
            @(negedge clk);
            if (rd_valid) npulse++;
        end
    end

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic run_cfg(input int r, input int d, input int pa, input int ra, input string tag);
        int s0;
        longint iv, ev;
        poll_en = 1'b0;
        repeat (50) @(negedge clk);
        wait (!in_frame);
        rate_sel = 2'(r); dwell_sel = 3'(d);
        phy_addr = 5'(pa); reg_addr = 5'(ra);
        repeat (50) @(negedge clk);
        s0 = starts;
        poll_en = 1'b1;
        wait (frames >= s0 + 3);
        ev = longint'((64 + exp_gap(d)) * exp_div(2'(r)));
        for (int k = 1; k <= 2; k++) begin
            iv = longint'((start_t[s0 + k] - start_t[s0 + k - 1]) / 10);
            chk(iv == ev, tag, iv, ev);
        end
        repeat (3) @(negedge clk);
        chk(npulse == frames, "R10 pulses", npulse, frames);
    endtask

    initial begin : main
        int  s0;
        time t_en;
        rst = 1'b1; poll_en = 1'b0; rate_sel = 2'd0; dwell_sel = 3'd0;
        phy_addr = '0; reg_addr = '0;
        repeat (5) @(negedge clk);
        chk(mdio_oe == 1'b0, "R1 oe in reset", longint'(mdio_oe), 0);
        chk(rd_valid == 1'b0, "R1 valid in reset", longint'(rd_valid), 0);
        chk(mdc == 1'b0, "R1 mdc in reset", longint'(mdc), 0);
        rst = 1'b0;
        repeat (600) @(negedge clk);
        chk(starts == 0, "R1 idle", starts, 0);
        chk(npulse == 0, "R9 no frame disabled", npulse, 0);

        // rate sweep, shortest gap
        for (int r = 0; r < 4; r++)
            run_cfg(r, 0, r * 7 + 1, r * 5 + 2, (r == 3) ? "R11 rate3" : "R2 rate");

        // gap sweep at the fast rate, reserved codes included
        for (int d = 0; d < 8; d++)
            run_cfg(2, d, 31 - d, d * 3, (d >= 6) ? "R7 reserved gap" : "R6 gap");

        // a couple of gaps at the mid rate
        run_cfg(1, 1, 21, 10, "R6 gap mid");
        run_cfg(1, 7, 10, 21, "R7 reserved mid");

        // R8: drop enable during a frame
        poll_en = 1'b0;
        repeat (50) @(negedge clk);
        wait (!in_frame);
        rate_sel = 2'd1; dwell_sel = 3'd3;
        repeat (50) @(negedge clk);
        s0 = starts;
        poll_en = 1'b1;
        wait (starts == s0 + 1);
        poll_en = 1'b0;
        wait (frames == starts);
        repeat (3) @(negedge clk);
        chk(npulse == frames, "R8 frame completes", npulse, frames);
        repeat (3000) @(negedge clk);
        chk(starts == s0 + 1, "R8 no new frame", starts, s0 + 1);
        chk(mdio_oe == 1'b0, "R8 released", longint'(mdio_oe), 0);

        // R8: drop enable during the gap, then re-enable
        rate_sel = 2'd0; dwell_sel = 3'd5;
        repeat (50) @(negedge clk);
        s0 = starts;
        poll_en = 1'b1;
        wait (frames == s0 + 1);
        repeat (300) @(negedge clk);
        poll_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(starts == s0 + 1, "R8 gap abandoned", starts, s0 + 1);
        t_en = $time;
        poll_en = 1'b1;
        wait (starts == s0 + 2);
        chk((start_t[s0 + 1] - t_en) <= 400, "R8 restart latency",
            longint'(start_t[s0 + 1] - t_en), 400);
        poll_en = 1'b0;
        wait (frames == starts);
        repeat (5) @(negedge clk);
        chk(npulse == frames, "R10 final pulses", npulse, frames);
        finish_run();
    end

endmodule